// File: doc/BRIEF.md
# Interrupt Priority Selector

This block keeps the pending state of a core's physical and virtual interrupt sources and, each cycle, picks at most one exception to take. The physical requests are a non-maskable-class request, a fast request and a normal request. The virtual sources come from two places: line inputs driven by an interrupt controller and level bits held in the hypervisor's control registers. The virtual sources are a normal interrupt, a fast interrupt, a non-maskable-class normal interrupt, a non-maskable-class fast interrupt and a system error. For each candidate, a separate masking unit supplies an "unmasked" flag, one bit per candidate. An external router supplies the target level of each physical candidate.

When a candidate is both pending and unmasked, and the acknowledge input is high, the block raises a one-cycle take pulse. With the pulse it presents the exception code and the target level, which stay on the outputs until the next take. Taking the virtual system error also raises a one-cycle clear strobe for its hypervisor source bit. The block then stops that source until the bit has been seen low. Performing the exception entry is left to the consumer.

Top module: `irq_prio_sel`

## Requirements
- R1: During and directly after reset, take, vse_clr, exc_code and exc_tgt are all 0, and no pending state survives reset.
- R2: The virtual normal interrupt is pending when (hv_vi and not hx_vnmi_sel) or ln_virq. The virtual fast interrupt is pending when (hv_vf and not hx_vfnmi_sel) or ln_vfiq.
- R3: The virtual non-maskable normal interrupt is pending when (hv_vi and hx_vnmi_sel) or ln_vnmi. The virtual non-maskable fast interrupt is pending when hv_vf and hx_vfnmi_sel; it has no line input. The virtual system error is pending when hv_vse is high.
- R4: The NMI stage is active only when nmi_present and nmi_enable are both 1. In that case the three non-maskable candidates are checked first, in this order: physical NMI (code 0), virtual NMI (code 1), virtual fast NMI (code 2).
- R5: After the NMI stage, the candidates are checked in this order: FIQ (code 3), IRQ (code 4), virtual IRQ (code 5), virtual FIQ (code 6), virtual system error (code 7). The first candidate that is pending and has its cand_ok bit set (bit index = code) wins.
- R6: When the NMI stage is inactive, a pending physical NMI counts as a pending IRQ, a pending virtual NMI as a pending virtual IRQ, and a pending virtual fast NMI as a pending virtual FIQ. Codes 0 to 2 are then never produced.
- R7: Codes 1, 2, 5, 6 and 7 target level VIRT_LVL. Code 0 takes phys_tgt slice 0, code 3 slice 1 and code 4 slice 2. Each slice is LVL_W bits wide, with slice k at bits [k*LVL_W +: LVL_W]. A folded NMI uses the IRQ slice.
- R8: An input applied before clock edge k is registered as pending at edge k. The take pulse is registered at edge k+1, from the cand_ok, ack, NMI-enable and phys_tgt values present before that edge. Take is never high in two consecutive cycles.
- R9: No exception is taken in a cycle that follows a low ack.
- R10: In every cycle without a take, exc_code and exc_tgt keep their previous values.
- R11: A take with code 7 has vse_clr high in the same cycle; vse_clr is never high otherwise. The system error is then not taken again until hv_vse has been sampled low at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_present | input | 1 | Non-maskable class feature implemented |
| nmi_enable | input | 1 | Non-maskable class enabled at the current level |
| req_nmi | input | 1 | Physical non-maskable request |
| req_fiq | input | 1 | Physical fast request |
| req_irq | input | 1 | Physical normal request |
| ln_virq | input | 1 | Controller line, virtual normal |
| ln_vfiq | input | 1 | Controller line, virtual fast |
| ln_vnmi | input | 1 | Controller line, virtual non-maskable normal |
| hv_vi | input | 1 | Hypervisor virtual normal bit |
| hv_vf | input | 1 | Hypervisor virtual fast bit |
| hv_vse | input | 1 | Hypervisor virtual system error bit |
| hx_vnmi_sel | input | 1 | Steers hv_vi to the non-maskable class |
| hx_vfnmi_sel | input | 1 | Steers hv_vf to the non-maskable class |
| phys_tgt | input | 3*LVL_W | Routed target levels of codes 0, 3, 4 |
| cand_ok | input | 8 | Unmasked flag per candidate, indexed by code |
| ack | input | 1 | Consumer ready to accept an exception |
| take | output | 1 | One-cycle take pulse |
| exc_code | output | 3 | Code of the taken exception |
| exc_tgt | output | LVL_W | Target level of the taken exception |
| vse_clr | output | 1 | Clear strobe for the hypervisor system error bit |

## Verification
The bench builds the block with LVL_W = 3 and VIRT_LVL = 1. With three bits, each of the three routed slices can carry a distinct value from 0 to 7. A target taken from the wrong slice, or a physical target replaced by the virtual constant, therefore shows up at exc_tgt. Random trials mix both NMI-stage settings, partial unmasking and a random ack. Directed cases cover the pending formulas, back-to-back requests and the clear-and-block sequence of the system error.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int NCAND  = 8;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    EX_NMI   = 3'd0,
    EX_VNMI  = 3'd1,
    EX_VFNMI = 3'd2,
    EX_FIQ   = 3'd3,
    EX_IRQ   = 3'd4,
    EX_VIRQ  = 3'd5,
    EX_VFIQ  = 3'd6,
    EX_VSERR = 3'd7
  } exc_e;

  // Pending vector indexed by exception code.
  function automatic logic [NCAND-1:0] raw_pending(
    input logic nmi, input logic fiq, input logic irq,
    input logic l_virq, input logic l_vfiq, input logic l_vnmi,
    input logic vi, input logic vf, input logic vse_eff,
    input logic vn_sel, input logic vf_sel);
    logic [NCAND-1:0] p;
    p           = '0;
    p[EX_NMI]   = nmi;
    p[EX_VNMI]  = (vi & vn_sel) | l_vnmi;
    p[EX_VFNMI] = vf & vf_sel;
    p[EX_FIQ]   = fiq;
    p[EX_IRQ]   = irq;
    p[EX_VIRQ]  = (vi & ~vn_sel) | l_virq;
    p[EX_VFIQ]  = (vf & ~vf_sel) | l_vfiq;
    p[EX_VSERR] = vse_eff;
    return p;
  endfunction

  // Without the NMI stage, superpriority sources merge into their peers.
  function automatic logic [NCAND-1:0] fold_pending(
    input logic [NCAND-1:0] p, input logic stage_on);
    logic [NCAND-1:0] f;
    f = p;
    if (!stage_on) begin
      f[EX_IRQ]   = p[EX_IRQ]  | p[EX_NMI];
      f[EX_VIRQ]  = p[EX_VIRQ] | p[EX_VNMI];
      f[EX_VFIQ]  = p[EX_VFIQ] | p[EX_VFNMI];
      f[EX_NMI]   = 1'b0;
      f[EX_VNMI]  = 1'b0;
      f[EX_VFNMI] = 1'b0;
    end
    return f;
  endfunction

  function automatic logic is_virtual(input logic [CODE_W-1:0] c);
    return !(c == EX_NMI || c == EX_FIQ || c == EX_IRQ);
  endfunction

  // Slice of the routed target vector that a physical code uses.
  function automatic int phys_slice(input logic [CODE_W-1:0] c);
    case (c)
      EX_FIQ:  return 1;
      EX_IRQ:  return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] onehot_index(input logic [NCAND-1:0] v);
    logic [CODE_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NCAND; i++) begin
      if (v[i]) idx = idx | CODE_W'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/irq_sel_pend.sv
module irq_sel_pend
  import irq_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_nmi,
  input  logic             req_fiq,
  input  logic             req_irq,
  input  logic             ln_virq,
  input  logic             ln_vfiq,
  input  logic             ln_vnmi,
  input  logic             hv_vi,
  input  logic             hv_vf,
  input  logic             hv_vse,
  input  logic             hx_vnmi_sel,
  input  logic             hx_vfnmi_sel,
  input  logic             vse_take,
  output logic [NCAND-1:0] pend_q
);

  logic             blk_q;
  logic             vse_eff;
  logic [NCAND-1:0] pend_d;

  // A system error being taken now, or taken since hv_vse was last low,
  // is no longer pending.
  assign vse_eff = hv_vse & ~blk_q & ~vse_take;

  always_comb begin
    pend_d = raw_pending(req_nmi, req_fiq, req_irq,
                         ln_virq, ln_vfiq, ln_vnmi,
                         hv_vi, hv_vf, vse_eff,
                         hx_vnmi_sel, hx_vfnmi_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      blk_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      blk_q  <= hv_vse ? (blk_q | vse_take) : 1'b0;
    end
  end

endmodule

// File: rtl/irq_sel_pick.sv
module irq_sel_pick
  import irq_sel_pkg::*;
#(
  parameter int LVL_W    = 2,
  parameter int VIRT_LVL = 1
) (
  input  logic [NCAND-1:0]   pend_q,
  input  logic               nmi_on,
  input  logic [NCAND-1:0]   cand_ok,
  input  logic [3*LVL_W-1:0] phys_tgt,
  output logic [NCAND-1:0]   elig,
  output logic               hit,
  output logic [CODE_W-1:0]  code,
  output logic [LVL_W-1:0]   tgt
);

  logic [NCAND-1:0] folded;
  logic [NCAND-1:0] win;
  logic [NCAND:0]   seen;

  assign folded  = fold_pending(pend_q, nmi_on);
  assign elig    = folded & cand_ok;
  assign seen[0] = 1'b0;

  // Lower code means higher priority: each stage yields to anything earlier.
  for (genvar i = 0; i < NCAND; i++) begin : g_chain
    assign win[i]    = elig[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig[i];
  end

  assign hit  = seen[NCAND];
  assign code = onehot_index(win);

  always_comb begin
    if (is_virtual(code)) begin
      tgt = LVL_W'(VIRT_LVL);
    end else begin
      tgt = phys_tgt[phys_slice(code)*LVL_W +: LVL_W];
    end
  end

endmodule

// File: rtl/irq_sel_out.sv
module irq_sel_out
  import irq_sel_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [CODE_W-1:0] code,
  input  logic [LVL_W-1:0]  tgt,
  input  logic              ack,
  output logic              fire,
  output logic              vse_take,
  output logic              take,
  output logic [CODE_W-1:0] exc_code,
  output logic [LVL_W-1:0]  exc_tgt,
  output logic              vse_clr
);

  // The cycle after a take is always a gap, so the pulse stays one cycle.
  assign fire     = hit & ack & ~take;
  assign vse_take = fire & (code == EX_VSERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      exc_code <= '0;
      exc_tgt  <= '0;
      vse_clr  <= 1'b0;
    end else begin
      take    <= fire;
      vse_clr <= vse_take;
      if (fire) begin
        exc_code <= code;
        exc_tgt  <= tgt;
      end
    end
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int LVL_W    = 2,
  parameter int VIRT_LVL = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_present,
  input  logic               nmi_enable,
  input  logic               req_nmi,
  input  logic               req_fiq,
  input  logic               req_irq,
  input  logic               ln_virq,
  input  logic               ln_vfiq,
  input  logic               ln_vnmi,
  input  logic               hv_vi,
  input  logic               hv_vf,
  input  logic               hv_vse,
  input  logic               hx_vnmi_sel,
  input  logic               hx_vfnmi_sel,
  input  logic [3*LVL_W-1:0] phys_tgt,
  input  logic [7:0]         cand_ok,
  input  logic               ack,
  output logic               take,
  output logic [2:0]         exc_code,
  output logic [LVL_W-1:0]   exc_tgt,
  output logic               vse_clr
);

  // Named internal events, also observed by the bound checker.
  logic               nmi_on;
  logic [NCAND-1:0]   pend_q;
  logic [NCAND-1:0]   elig;
  logic               hit;
  logic [CODE_W-1:0]  pick_code;
  logic [LVL_W-1:0]   pick_tgt;
  logic               fire;
  logic               vse_take;

  assign nmi_on = nmi_present & nmi_enable;

  irq_sel_pend u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_nmi      (req_nmi),
    .req_fiq      (req_fiq),
    .req_irq      (req_irq),
    .ln_virq      (ln_virq),
    .ln_vfiq      (ln_vfiq),
    .ln_vnmi      (ln_vnmi),
    .hv_vi        (hv_vi),
    .hv_vf        (hv_vf),
    .hv_vse       (hv_vse),
    .hx_vnmi_sel  (hx_vnmi_sel),
    .hx_vfnmi_sel (hx_vfnmi_sel),
    .vse_take     (vse_take),
    .pend_q       (pend_q)
  );

  irq_sel_pick #(.LVL_W(LVL_W), .VIRT_LVL(VIRT_LVL)) u_pick (
    .pend_q   (pend_q),
    .nmi_on   (nmi_on),
    .cand_ok  (cand_ok),
    .phys_tgt (phys_tgt),
    .elig     (elig),
    .hit      (hit),
    .code     (pick_code),
    .tgt      (pick_tgt)
  );

  irq_sel_out #(.LVL_W(LVL_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .code     (pick_code),
    .tgt      (pick_tgt),
    .ack      (ack),
    .fire     (fire),
    .vse_take (vse_take),
    .take     (take),
    .exc_code (exc_code),
    .exc_tgt  (exc_tgt),
    .vse_clr  (vse_clr)
  );

endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk #(
  parameter int LVL_W    = 2,
  parameter int VIRT_LVL = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             nmi_on,
  input logic [7:0]       pend_q,
  input logic             take,
  input logic [2:0]       exc_code,
  input logic [LVL_W-1:0] exc_tgt,
  input logic             vse_clr
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  a_r9_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(ack));

  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> ($stable(exc_code) && $stable(exc_tgt)));

  a_r11_clr_only_on_vserr: assert property (@(posedge clk) disable iff (!rst_n)
    vse_clr |-> (take && exc_code == 3'd7));

  a_r11_clr_with_vserr: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exc_code == 3'd7) |-> vse_clr);

  a_r11_pending_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exc_code == 3'd7) |-> !pend_q[7]);

  a_r7_virtual_level: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !(exc_code == 3'd0 || exc_code == 3'd3 || exc_code == 3'd4))
      |-> (exc_tgt == LVL_W'(VIRT_LVL)));

  a_r6_no_nmi_codes_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exc_code < 3'd3) |-> $past(nmi_on));

endmodule

bind irq_prio_sel irq_prio_sel_chk #(.LVL_W(LVL_W), .VIRT_LVL(VIRT_LVL)) u_chk (.*);

// File: tb/irq_prio_sel_tb.sv
module irq_prio_sel_tb;

  localparam int LW = 3;
  localparam int VL = 1;

  typedef struct packed {
    logic          present, enable;
    logic          nmi, fiq, irq;
    logic          lvirq, lvfiq, lvnmi;
    logic          vi, vf, vse, vnsel, vfsel;
    logic [3*LW-1:0] tgt;
    logic [7:0]    ok;
    logic          ack;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  stim_t s;
  logic take, vse_clr;
  logic [2:0] exc_code;
  logic [LW-1:0] exc_tgt;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] h_code = 3'd0;
  logic [LW-1:0] h_tgt = '0;

  always #4 clk = ~clk;

  irq_prio_sel #(.LVL_W(LW), .VIRT_LVL(VL)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .nmi_present(s.present), .nmi_enable(s.enable),
    .req_nmi(s.nmi), .req_fiq(s.fiq), .req_irq(s.irq),
    .ln_virq(s.lvirq), .ln_vfiq(s.lvfiq), .ln_vnmi(s.lvnmi),
    .hv_vi(s.vi), .hv_vf(s.vf), .hv_vse(s.vse),
    .hx_vnmi_sel(s.vnsel), .hx_vfnmi_sel(s.vfsel),
    .phys_tgt(s.tgt), .cand_ok(s.ok), .ack(s.ack),
    .take(take), .exc_code(exc_code), .exc_tgt(exc_tgt), .vse_clr(vse_clr)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected outcome: {hit, code, target}, restated from the requirements.
  function automatic logic [3+LW:0] model(input stim_t t);
    logic [7:0] p;
    logic on;
    logic [LW-1:0] lvl;
    on   = t.present && t.enable;
    p[0] = t.nmi;
    p[1] = t.lvnmi || (t.vi && t.vnsel);
    p[2] = t.vf && t.vfsel;
    p[3] = t.fiq;
    p[4] = t.irq;
    p[5] = t.lvirq || (t.vi && !t.vnsel);
    p[6] = t.lvfiq || (t.vf && !t.vfsel);
    p[7] = t.vse;
    if (!on) begin
      if (p[0]) p[4] = 1'b1;
      if (p[1]) p[5] = 1'b1;
      if (p[2]) p[6] = 1'b1;
      p[2:0] = 3'b000;
    end
    for (int c = 0; c < 8; c++) begin
      if (p[c] && t.ok[c]) begin
        case (c)
          0: lvl = t.tgt[LW-1:0];
          3: lvl = t.tgt[2*LW-1:LW];
          4: lvl = t.tgt[3*LW-1:2*LW];
          default: lvl = LW'(VL);
        endcase
        return {1'b1, 3'(c), lvl};
      end
    end
    return '0;
  endfunction

  task automatic trial(input stim_t t, input string req);
    logic [3+LW:0] e;
    stim_t q;
    @(negedge clk); s = '0;
    @(negedge clk);
    q = t; q.ack = 1'b0; s = q;
    @(negedge clk);
    @(negedge clk);
    s.ack = t.ack;
    @(negedge clk);
    e = model(t);
    if (!t.ack) e[3+LW] = 1'b0;
    check(req, "take", int'(take), int'(e[3+LW]));
    if (e[3+LW]) begin h_code = e[LW+2:LW]; h_tgt = e[LW-1:0]; end
    check(req, "code", int'(exc_code), int'(h_code));
    check(req, "tgt", int'(exc_tgt), int'(h_tgt));
    check("R11", "vse_clr", int'(vse_clr), int'(e[3+LW] && h_code == 3'd7));
    s.ack = 1'b0;
  endtask

  function automatic stim_t base();
    stim_t t;
    t = '0;
    t.ok = 8'hFF;
    t.ack = 1'b1;
    t.tgt = {3'd6, 3'd5, 3'd3};
    return t;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    stim_t t;
    void'($urandom(32'h5EED_1234));
    s = '0;
    repeat (3) @(negedge clk);
    check("R1", "take in reset", int'(take), 0);
    check("R1", "code in reset", int'(exc_code), 0);
    check("R1", "tgt in reset", int'(exc_tgt), 0);
    check("R1", "vse_clr in reset", int'(vse_clr), 0);
    s.irq = 1'b1;  // pending must not be carried over from reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "take after reset", int'(take), 0);
    s = '0;

    // R2 / R3 pending formulas, NMI stage on
    t = base(); t.present = 1; t.enable = 1;
    t.vi = 1; t.vnsel = 1;              trial(t, "R3 vi+sel->vnmi");
    t.vnsel = 0;                        trial(t, "R2 vi->virq");
    t = base(); t.present = 1; t.enable = 1;
    t.vf = 1; t.vfsel = 1;              trial(t, "R3 vf+sel->vfnmi");
    t.vfsel = 0;                        trial(t, "R2 vf->vfiq");
    t = base(); t.present = 1; t.enable = 1;
    t.lvfiq = 1; t.vfsel = 1;           trial(t, "R2 vfiq line");
    t = base(); t.lvnmi = 1; t.present = 1; t.enable = 1; trial(t, "R3 vnmi line");
    t = base(); t.vse = 1;              trial(t, "R3 vserr");

    // R4 order in NMI stage
    t = base(); t.present = 1; t.enable = 1;
    t.nmi = 1; t.lvnmi = 1; t.fiq = 1;  trial(t, "R4 nmi first");
    t.ok[0] = 0;                        trial(t, "R4 vnmi next");
    // R6 fold with stage off
    t = base(); t.present = 1; t.nmi = 1; trial(t, "R6 nmi as irq");
    t = base(); t.enable = 1; t.vf = 1; t.vfsel = 1; trial(t, "R6 vfnmi as vfiq");
    t = base(); t.lvnmi = 1; t.ok[5] = 0; trial(t, "R6 vnmi masked as virq");
    // R5 order and masking
    t = base(); t.fiq = 1; t.irq = 1; t.lvirq = 1; t.vse = 1; trial(t, "R5 fiq first");
    t.ok[3] = 0; t.ok[4] = 0;           trial(t, "R5 skip masked");
    t.ok = 8'h00;                       trial(t, "R10 none eligible");
    // R7 targets
    t = base(); t.fiq = 1;              trial(t, "R7 fiq slice");
    t = base(); t.irq = 1;              trial(t, "R7 irq slice");
    // R9 ack low
    t = base(); t.irq = 1; t.ack = 0;   trial(t, "R9 ack low");

    // R8 back-to-back: held request, ack high
    @(negedge clk); s = base(); s.irq = 1; s.ack = 0;
    @(negedge clk); @(negedge clk); s.ack = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8", "alternate take", int'(take), (k % 2 == 0) ? 1 : 0);
    end
    h_code = 3'd4; h_tgt = 3'd6;
    check("R8", "code", int'(exc_code), 4);

    // R11 system error clear and block
    @(negedge clk); s = '0;
    @(negedge clk); s = base(); s.vse = 1;
    @(negedge clk); @(negedge clk);
    check("R11", "vserr take", int'(take), 1);
    check("R11", "vserr clr", int'(vse_clr), 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11", "no retake while vse high", int'(take), 0);
    end
    s.vse = 0;
    @(negedge clk); s.vse = 1;
    @(negedge clk); @(negedge clk);
    check("R11", "retake after vse low", int'(take), 1);
    check("R11", "retake code", int'(exc_code), 7);
    h_code = 3'd7; h_tgt = LW'(VL);
    s.ack = 0;

    // Random trials
    for (int n = 0; n < 400; n++) begin
      t = '0;
      t.present = 1'($urandom % 4 != 0);
      t.enable  = 1'($urandom % 3 != 0);
      t.nmi = 1'($urandom % 4 == 0); t.fiq = 1'($urandom % 4 == 0);
      t.irq = 1'($urandom % 4 == 0); t.lvirq = 1'($urandom % 4 == 0);
      t.lvfiq = 1'($urandom % 4 == 0); t.lvnmi = 1'($urandom % 4 == 0);
      t.vi = 1'($urandom % 4 == 0); t.vf = 1'($urandom % 4 == 0);
      t.vse = 1'($urandom % 4 == 0);
      t.vnsel = 1'($urandom); t.vfsel = 1'($urandom);
      t.tgt = (3*LW)'($urandom);
      for (int b = 0; b < 8; b++) t.ok[b] = 1'($urandom % 10 < 7);
      t.ack = 1'($urandom % 8 != 0);
      trial(t, "R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule